// File: doc/BRIEF.md
# Sign-Sign Equalizer and Reference-Level Adaptation Engine

This block trims a serial receiver's equalizer with only one added error sampler. Each symbol brings a data decision and a one-bit error. The error bit says whether the received sample sat above or below a programmable reference level. From these two bits the engine runs two coupled sign-sign loops. The first loop moves the reference level toward the amplitude of positive symbols. The second loop moves a set of signed tap weights toward zero correlation between the error and past decisions. Each loop has its own step size, so their relative speeds can be set over a wide range.

A partial-response mode handles receivers that tolerate one post-cursor. In this mode the engine filters on the two most recent decisions and learns two separate levels. One level is learned from a positive symbol that follows a positive symbol, the other from a positive symbol that follows a negative one. The post-cursor estimate is half their difference. A controller switches between this mode and the equalizer mode. On request, the tap set can be halved repeatedly until its total magnitude fits a peak output budget.

A decimation count spaces the updates. A freeze input stops all adaptation. Reset loads programmable start values.

Top module: `dual_loop_adapt`

## Requirements
- R1: While `rst_n` is low, `lev_out`, `lev_hi` and `lev_lo` equal `init_lev`, and tap k equals the k-th WW-bit slice of `init_tap` (tap 0 in the lowest bits). `alpha_out` is 0.
- R2: With `pr_mode` low, a symbol qualifies when `sym_valid`=1 and `data_msb`=1. On an update, `lev_out` grows by `step_lev` if `err_sign`=1 (sample above the level) and shrinks by `step_lev` if `err_sign`=0. Symbols with `data_msb`=0, and cycles with `sym_valid`=0, never change it. In this mode `lev_hi` and `lev_lo` hold.
- R3: On an update with `pr_mode` low, tap k moves by `step_tap`. It moves up when d(n-k) differs from `err_sign` and down otherwise. Here d(n) is the present `data_msb`, and d(n-k) is the decision of the k-th earlier valid symbol (0 after reset).
- R4: Every level and tap saturates at its signed limits (-128 and +127 at width 8) and never wraps.
- R5: Updates happen on every M-th qualifying symbol, where M=`decim_m` and 0 acts as 1. The first update after reset falls on the M-th qualifying symbol.
- R6: With `pr_mode` high, `pr_sel`=0 qualifies only a positive symbol whose previous decision was 1, and it steps `lev_hi`. `pr_sel`=1 qualifies only a positive symbol whose previous decision was 0, and it steps `lev_lo`. Both follow the step rule of R2. `lev_out` and the taps hold, while decision history keeps shifting.
- R7: `alpha_out` equals floor((`lev_hi` - `lev_lo`)/2).
- R8: In the first unfrozen cycle with `pr_mode` high after it was low, both `lev_hi` and `lev_lo` load `init_lev`, and that cycle's symbol is not counted.
- R9: When `scale_req`=1 and the sum of tap magnitudes exceeds `peak_lim`, every tap is arithmetically shifted right by one in the next cycle. A tap step that falls in the same cycle is dropped, while the level step and the decimation count still proceed. Otherwise `scale_req` changes nothing.
- R10: While `freeze`=1, no level, tap, history, count or mode-tracking state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Hold all adaptation state |
| pr_mode | input | 1 | Partial-response level learning when 1, equalizer mode when 0 |
| pr_sel | input | 1 | Pattern choice in partial-response mode (0: previous 1, 1: previous 0) |
| sym_valid | input | 1 | A decision and error bit are present this cycle |
| data_msb | input | 1 | Data decision, 1 = positive |
| err_sign | input | 1 | 1 = sample above the reference level |
| decim_m | input | DCW | Qualifying symbols per update (0 acts as 1) |
| step_lev | input | SW | Level step size |
| step_tap | input | SW | Tap step size |
| init_lev | input | LW | Start value of all levels |
| init_tap | input | NTAPS*WW | Start values of the taps, tap 0 lowest |
| scale_req | input | 1 | Request one halving step of the taps |
| peak_lim | input | WW+1+clog2(NTAPS) | Budget for the sum of tap magnitudes |
| lev_out | output | LW | Equalizer-mode reference level |
| lev_hi | output | LW | Level learned after a positive decision |
| lev_lo | output | LW | Level learned after a negative decision |
| alpha_out | output | LW | Post-cursor estimate |
| tap_out | output | NTAPS*WW | Tap weights, tap 0 lowest |

## Verification
A tap step and a rescale can fall in the same cycle. The bench provokes this by raising `scale_req` at random, with budgets both above and below the current magnitude sum, while qualifying symbols keep firing updates. It expects halved taps with the step dropped, and the level still stepping. A second collision is a mode entry in the same cycle as a qualifying symbol: the reload must win and the count must stay put. Both cases are judged by a per-cycle arithmetic model kept in the bench.

// File: rtl/adapt_pkg.sv
package adapt_pkg;

  // Direction of a sign-sign tap step: up when decision and error disagree.
  function automatic logic tap_up(input logic dk, input logic err_above);
    return dk != err_above;
  endfunction

  // Symbol qualification: positive now; in pattern mode also gated on the previous decision.
  function automatic logic pattern_hit(input logic pr_on, input logic sel,
                                       input logic cur, input logic prev);
    if (!pr_on) return cur;
    return cur && (sel ? !prev : prev);
  endfunction

endpackage

// File: rtl/adapt_qualify.sv
module adapt_qualify import adapt_pkg::*; #(
  parameter int NTAPS = 3,
  parameter int DCW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             sym_valid,
  input  logic             pr_mode,
  input  logic             pr_sel,
  input  logic             data_msb,
  input  logic [DCW-1:0]   decim_m,
  output logic [NTAPS-1:0] dvec,
  output logic             qual_hit,
  output logic             upd_fire,
  output logic             pr_enter
);
  logic [NTAPS-2:0] hist;
  logic [DCW-1:0]   cnt;
  logic [DCW-1:0]   lim_m1;
  logic             pr_q;

  assign dvec     = {hist, data_msb};
  assign pr_enter = pr_mode & ~pr_q & ~freeze;
  assign lim_m1   = (decim_m == '0) ? '0 : decim_m - 1'b1;
  assign qual_hit = sym_valid & ~freeze & ~pr_enter
                  & pattern_hit(pr_mode, pr_sel, data_msb, hist[0]);
  assign upd_fire = qual_hit & (cnt >= lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
      pr_q <= 1'b0;
    end else if (!freeze) begin
      pr_q <= pr_mode;
      if (sym_valid) hist <= dvec[NTAPS-2:0];
      if (qual_hit)  cnt  <= upd_fire ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adapt_level.sv
module adapt_level #(
  parameter int LW = 8,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pr_mode,
  input  logic                 pr_sel,
  input  logic                 upd_fire,
  input  logic                 pr_enter,
  input  logic                 err_above,
  input  logic [SW-1:0]        step_lev,
  input  logic signed [LW-1:0] init_lev,
  output logic signed [LW-1:0] lev_main,
  output logic signed [LW-1:0] lev_hi,
  output logic signed [LW-1:0] lev_lo,
  output logic signed [LW-1:0] alpha
);
  localparam logic signed [LW:0] XMAX = {2'b00, {(LW-1){1'b1}}};
  localparam logic signed [LW:0] XMIN = {2'b11, {(LW-1){1'b0}}};

  function automatic logic signed [LW-1:0] lev_move(input logic signed [LW-1:0] v,
                                                    input logic [SW-1:0] s,
                                                    input logic up);
    logic signed [LW:0] t;
    logic signed [LW:0] se;
    se = $signed({{(LW+1-SW){1'b0}}, s});
    t  = up ? ($signed({v[LW-1], v}) + se) : ($signed({v[LW-1], v}) - se);
    if (t > XMAX) return XMAX[LW-1:0];
    if (t < XMIN) return XMIN[LW-1:0];
    return t[LW-1:0];
  endfunction

  logic signed [LW:0] diff;
  assign diff  = $signed({lev_hi[LW-1], lev_hi}) - $signed({lev_lo[LW-1], lev_lo});
  assign alpha = diff[LW:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lev_main <= init_lev;
      lev_hi   <= init_lev;
      lev_lo   <= init_lev;
    end else begin
      if (pr_enter) begin
        lev_hi <= init_lev;
        lev_lo <= init_lev;
      end else if (upd_fire && pr_mode) begin
        if (pr_sel) lev_lo <= lev_move(lev_lo, step_lev, err_above);
        else        lev_hi <= lev_move(lev_hi, step_lev, err_above);
      end
      if (upd_fire && !pr_mode) lev_main <= lev_move(lev_main, step_lev, err_above);
    end
  end
endmodule

// File: rtl/adapt_taps.sv
module adapt_taps import adapt_pkg::*; #(
  parameter int NTAPS = 3,
  parameter int WW    = 8,
  parameter int SW    = 4,
  parameter int SUMW  = WW + 1 + $clog2(NTAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                freeze,
  input  logic                pr_mode,
  input  logic                upd_fire,
  input  logic                scale_req,
  input  logic [NTAPS-1:0]    dvec,
  input  logic                err_above,
  input  logic [SW-1:0]       step_tap,
  input  logic [NTAPS*WW-1:0] init_tap,
  input  logic [SUMW-1:0]     peak_lim,
  output logic [NTAPS*WW-1:0] tap_flat,
  output logic [SUMW-1:0]     tap_sum,
  output logic                scale_fire
);
  localparam logic signed [WW:0] XMAX = {2'b00, {(WW-1){1'b1}}};
  localparam logic signed [WW:0] XMIN = {2'b11, {(WW-1){1'b0}}};

  function automatic logic signed [WW-1:0] tap_move(input logic signed [WW-1:0] v,
                                                    input logic [SW-1:0] s,
                                                    input logic up);
    logic signed [WW:0] t;
    logic signed [WW:0] se;
    se = $signed({{(WW+1-SW){1'b0}}, s});
    t  = up ? ($signed({v[WW-1], v}) + se) : ($signed({v[WW-1], v}) - se);
    if (t > XMAX) return XMAX[WW-1:0];
    if (t < XMIN) return XMIN[WW-1:0];
    return t[WW-1:0];
  endfunction

  logic [WW:0] mag [NTAPS];
  logic        tap_step;

  assign scale_fire = scale_req & ~freeze & (tap_sum > peak_lim);
  assign tap_step   = upd_fire & ~pr_mode;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [WW-1:0] w;
    assign tap_flat[k*WW +: WW] = w;
    assign mag[k] = w[WW-1] ? (~{w[WW-1], w} + 1'b1) : {1'b0, w};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          w <= init_tap[k*WW +: WW];
      else if (scale_fire) w <= {w[WW-1], w[WW-1:1]};
      else if (tap_step)   w <= tap_move(w, step_tap, tap_up(dvec[k], err_above));
    end
  end

  always_comb begin
    tap_sum = '0;
    for (int k = 0; k < NTAPS; k++)
      tap_sum = tap_sum + {{(SUMW-WW-1){1'b0}}, mag[k]};
  end
endmodule

// File: rtl/dual_loop_adapt.sv
module dual_loop_adapt #(
  parameter int NTAPS = 3,
  parameter int WW    = 8,
  parameter int LW    = 8,
  parameter int SW    = 4,
  parameter int DCW   = 4,
  localparam int SUMW = WW + 1 + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 freeze,
  input  logic                 pr_mode,
  input  logic                 pr_sel,
  input  logic                 sym_valid,
  input  logic                 data_msb,
  input  logic                 err_sign,
  input  logic [DCW-1:0]       decim_m,
  input  logic [SW-1:0]        step_lev,
  input  logic [SW-1:0]        step_tap,
  input  logic signed [LW-1:0] init_lev,
  input  logic [NTAPS*WW-1:0]  init_tap,
  input  logic                 scale_req,
  input  logic [SUMW-1:0]      peak_lim,
  output logic signed [LW-1:0] lev_out,
  output logic signed [LW-1:0] lev_hi,
  output logic signed [LW-1:0] lev_lo,
  output logic signed [LW-1:0] alpha_out,
  output logic [NTAPS*WW-1:0]  tap_out
);
  // Internal events brought out by name for the checker.
  logic [NTAPS-1:0] dvec;
  logic             qual_hit;
  logic             upd_fire;
  logic             pr_enter;
  logic             scale_fire;
  logic [SUMW-1:0]  tap_sum;

  adapt_qualify #(.NTAPS(NTAPS), .DCW(DCW)) u_qual (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .sym_valid(sym_valid),
    .pr_mode(pr_mode), .pr_sel(pr_sel), .data_msb(data_msb), .decim_m(decim_m),
    .dvec(dvec), .qual_hit(qual_hit), .upd_fire(upd_fire), .pr_enter(pr_enter)
  );

  adapt_level #(.LW(LW), .SW(SW)) u_level (
    .clk(clk), .rst_n(rst_n), .pr_mode(pr_mode), .pr_sel(pr_sel),
    .upd_fire(upd_fire), .pr_enter(pr_enter), .err_above(err_sign),
    .step_lev(step_lev), .init_lev(init_lev),
    .lev_main(lev_out), .lev_hi(lev_hi), .lev_lo(lev_lo), .alpha(alpha_out)
  );

  adapt_taps #(.NTAPS(NTAPS), .WW(WW), .SW(SW), .SUMW(SUMW)) u_taps (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .pr_mode(pr_mode),
    .upd_fire(upd_fire), .scale_req(scale_req), .dvec(dvec),
    .err_above(err_sign), .step_tap(step_tap), .init_tap(init_tap),
    .peak_lim(peak_lim), .tap_flat(tap_out), .tap_sum(tap_sum),
    .scale_fire(scale_fire)
  );
endmodule

// File: rtl/dual_loop_adapt_chk.sv
module dual_loop_adapt_chk #(
  parameter int NTAPS = 3,
  parameter int WW    = 8,
  parameter int LW    = 8,
  parameter int SUMW  = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                freeze,
  input logic                pr_mode,
  input logic                upd_fire,
  input logic                scale_fire,
  input logic                pr_enter,
  input logic [LW-1:0]       lev_out,
  input logic [LW-1:0]       lev_hi,
  input logic [LW-1:0]       lev_lo,
  input logic [NTAPS*WW-1:0] tap_out,
  input logic [SUMW-1:0]     tap_sum
);
  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(lev_out) && $stable(lev_hi) && $stable(lev_lo) && $stable(tap_out));

  // R2
  main_level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_fire || pr_mode) |=> $stable(lev_out));

  // R2
  pair_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_mode |=> $stable(lev_hi) && $stable(lev_lo));

  // R8
  pair_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_enter |=> lev_hi == lev_lo);

  // R9
  rescale_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scale_fire |=> tap_sum <= $past(tap_sum));

  // R3
  tap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!upd_fire || pr_mode) && !scale_fire) |=> $stable(tap_out));
endmodule

bind dual_loop_adapt dual_loop_adapt_chk #(
  .NTAPS(NTAPS), .WW(WW), .LW(LW), .SUMW(SUMW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .pr_mode(pr_mode),
  .upd_fire(upd_fire), .scale_fire(scale_fire), .pr_enter(pr_enter),
  .lev_out(lev_out), .lev_hi(lev_hi), .lev_lo(lev_lo),
  .tap_out(tap_out), .tap_sum(tap_sum)
);

// File: tb/dual_loop_adapt_bench.sv
module dual_loop_adapt_bench;
  localparam int NT = 3, WW = 8, LW = 8, SW = 4, DCW = 4, SUMW = 11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, freeze, pr_mode, pr_sel, sym_valid, data_msb, err_sign, scale_req;
  logic [DCW-1:0] decim_m;
  logic [SW-1:0] step_lev, step_tap;
  logic signed [LW-1:0] init_lev;
  logic [NT*WW-1:0] init_tap;
  logic [SUMW-1:0] peak_lim;
  logic signed [LW-1:0] lev_out, lev_hi, lev_lo, alpha_out;
  logic [NT*WW-1:0] tap_out;

  dual_loop_adapt u_dual_loop_adapt (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .pr_mode(pr_mode), .pr_sel(pr_sel),
    .sym_valid(sym_valid), .data_msb(data_msb), .err_sign(err_sign),
    .decim_m(decim_m), .step_lev(step_lev), .step_tap(step_tap),
    .init_lev(init_lev), .init_tap(init_tap), .scale_req(scale_req),
    .peak_lim(peak_lim), .lev_out(lev_out), .lev_hi(lev_hi), .lev_lo(lev_lo),
    .alpha_out(alpha_out), .tap_out(tap_out)
  );

  int n_chk = 0, n_bad = 0;
  int m_lev, m_hi, m_lo, m_cnt;
  int m_tap [NT];
  bit m_hist [NT-1];
  bit m_prq;

  function automatic int sx8(input logic [7:0] b);
    logic signed [7:0] t;
    t = b;
    return int'(t);
  endfunction

  function automatic int clampw(input int v, input int w);
    int hi, lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "lev_out", int'(lev_out), m_lev);
    check(tag, "lev_hi", int'(lev_hi), m_hi);
    check(tag, "lev_lo", int'(lev_lo), m_lo);
    check(tag, "alpha_out", int'(alpha_out), (m_hi - m_lo) >>> 1);
    for (int k = 0; k < NT; k++)
      check(tag, $sformatf("tap%0d", k), sx8(tap_out[k*WW +: WW]), m_tap[k]);
  endtask

  task automatic model_reset();
    m_lev = int'(init_lev); m_hi = m_lev; m_lo = m_lev;
    for (int k = 0; k < NT; k++) m_tap[k] = sx8(init_tap[k*WW +: WW]);
    for (int k = 0; k < NT-1; k++) m_hist[k] = 1'b0;
    m_cnt = 0; m_prq = 1'b0;
  endtask

  task automatic model_step();
    int mlim, sum, sl, st, dk;
    bit enter, hit, fire, scl;
    if (freeze) return;
    enter = pr_mode && !m_prq;
    m_prq = pr_mode;
    hit = sym_valid && !enter && data_msb && (!pr_mode || (pr_sel ? !m_hist[0] : m_hist[0]));
    mlim = (decim_m == 0) ? 1 : int'(decim_m);
    fire = hit && (m_cnt >= mlim - 1);
    if (hit) m_cnt = fire ? 0 : m_cnt + 1;
    sum = 0;
    for (int k = 0; k < NT; k++) sum += (m_tap[k] < 0) ? -m_tap[k] : m_tap[k];
    scl = scale_req && (sum > int'(peak_lim));
    sl = err_sign ? int'(step_lev) : -int'(step_lev);
    if (enter) begin
      m_hi = int'(init_lev); m_lo = int'(init_lev);
    end else if (fire && pr_mode) begin
      if (pr_sel) m_lo = clampw(m_lo + sl, LW);
      else        m_hi = clampw(m_hi + sl, LW);
    end
    if (fire && !pr_mode) m_lev = clampw(m_lev + sl, LW);
    for (int k = 0; k < NT; k++) begin
      dk = (k == 0) ? int'(data_msb) : int'(m_hist[k-1]);
      st = (dk != int'(err_sign)) ? int'(step_tap) : -int'(step_tap);
      if (scl) m_tap[k] = m_tap[k] >>> 1;
      else if (fire && !pr_mode) m_tap[k] = clampw(m_tap[k] + st, WW);
    end
    if (sym_valid) begin
      for (int k = NT-2; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = data_msb;
    end
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic rand_sym(input int pos_bias);
    sym_valid = ($urandom % 4) != 0;
    data_msb  = ($urandom % 100) < pos_bias;
    err_sign  = $urandom % 2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(7));
    rst_n = 0; freeze = 0; pr_mode = 0; pr_sel = 0; sym_valid = 0; data_msb = 0;
    err_sign = 0; scale_req = 0; decim_m = 1; step_lev = 1; step_tap = 1;
    init_lev = 8'sd20; init_tap = {8'h05, 8'hF6, 8'h3C}; peak_lim = 11'd400;
    repeat (3) @(negedge clk);
    model_reset();
    compare_all("R1");
    rst_n = 1;

    // Equalizer mode sweep over decimation settings.
    for (int dm = 0; dm < 5; dm++) begin
      decim_m = dm[DCW-1:0];
      for (int i = 0; i < 150; i++) begin
        rand_sym(65);
        step_lev = $urandom % 16; step_tap = $urandom % 4;
        cyc("R2 R3 R5");
      end
    end

    // Drive both ends of the signed range.
    decim_m = 1; step_lev = 15; step_tap = 15; sym_valid = 1; data_msb = 1;
    err_sign = 0;
    for (int i = 0; i < 30; i++) cyc("R4");
    err_sign = 1;
    for (int i = 0; i < 30; i++) cyc("R4");

    // Rescale, alone and colliding with tap steps.
    sym_valid = 0; peak_lim = 11'd100;
    for (int i = 0; i < 4; i++) begin scale_req = 1; cyc("R9"); end
    for (int i = 0; i < 250; i++) begin
      rand_sym(70);
      step_lev = $urandom % 8; step_tap = 1 + $urandom % 15;
      scale_req = $urandom % 2; peak_lim = $urandom % 400;
      cyc("R9");
    end
    scale_req = 0;

    // Partial-response learning with repeated entries.
    for (int rep = 0; rep < 6; rep++) begin
      pr_mode = 0;
      for (int i = 0; i < 5; i++) begin rand_sym(60); cyc("R6 R8"); end
      init_lev = $urandom % 60;
      decim_m = $urandom % 3;
      pr_mode = 1;
      for (int i = 0; i < 80; i++) begin
        if (i % 20 == 0) pr_sel = ~pr_sel;
        rand_sym(70);
        step_lev = $urandom % 6;
        cyc("R6 R7 R8");
      end
    end

    // Freeze mixed with every function.
    for (int i = 0; i < 400; i++) begin
      freeze = ($urandom % 10) < 3;
      if ($urandom % 40 == 0) pr_mode = ~pr_mode;
      pr_sel = $urandom % 2;
      rand_sym(60);
      scale_req = ($urandom % 8) == 0; peak_lim = $urandom % 300;
      step_lev = $urandom % 16; step_tap = $urandom % 16;
      decim_m = $urandom % 3;
      cyc("R10");
    end
    freeze = 0;
    finish_run();
  end
endmodule